// File: doc/BRIEF.md
# Parallel Port Host Register Interface

This block is the host-side register file of a PC-style parallel port. A host issues byte accesses through a valid/ready request channel. The block decodes a 3-bit offset inside an eight-byte window placed at a configurable base address. It holds the output data latch and the control lines that drive the connector. It samples the connector status lines and chooses which way the data bus points. It also raises an interrupt when the printer acknowledges a byte.

Offsets 3 and 4 do not hold local storage. An access there becomes an address or data transfer cycle on a separate valid/ready channel toward a pin sequencer. The block does not model the pin-level wait timing itself. While that cycle is pending, the host channel drops `host_ready`, so the host is held off until the sequencer accepts the cycle. A read answer always comes back on `host_rvalid`. It takes one cycle for local registers and arrives one cycle after the handshake for transfer-cycle reads. The response channel has no back-pressure.

Top module: `lpt_regif`

## Requirements
- R1: An access is taken when `host_valid` and `host_ready` are both high. It affects the block only if `host_addr[15:3]` equals `BASE_ADDR[15:3]`. Any other address changes nothing, and a read there returns 8'hFF.
- R2: Only `host_size` = 0 (byte) is honoured. A wider access changes no register and starts no transfer cycle, and a read of that kind returns 8'hFF.
- R3: A write at offset 0 loads `pd_out`. In forward direction (`pd_oe` = 1), a read at offset 0 returns the latch.
- R4: A write at offset 2 stores the value with bits 7 and 6 set and bit 5 cleared. Stored bits 0, 1, 2 and 3 drive `ctl_strobe`, `ctl_autofd`, `ctl_init` and `ctl_select`, and bit 4 enables the acknowledge interrupt. A read at offset 2 returns the stored value.
- R5: Bit 5 of a control write sets the direction: 1 gives reverse (`pd_oe` = 0) and 0 gives forward. In reverse, a read at offset 0 returns `pd_in` and also loads that value into the latch.
- R6: A read at offset 1 returns {busy, synchronized ack level, paper out, select, error, irq, 1, timeout}, from bit 7 down to bit 0.
- R7: A falling edge of the synchronized `st_ack_n` sets the interrupt only while control bit 4 is set. The interrupt appears on `irq_lines[IRQ_LINE]`, and every other line stays low.
- R8: A read at offset 1 clears the interrupt. An acknowledge edge detected in the same cycle wins.
- R9: A write at offset 3 or 4 raises `epp_valid` with `epp_write` = 1, `epp_addr_cyc` = 1 for offset 3 and 0 for offset 4, and the byte on `epp_wdata`. These stay stable until `epp_ready`. `host_ready` is low while `epp_valid` is high.
- R10: A read at offset 3 or 4 raises a cycle with `epp_write` = 0. `host_rvalid` follows one cycle after the handshake, carrying the `epp_rdata` present at that handshake.
- R11: Writes at offsets 1, 5, 6 and 7 change nothing. Reads at offsets 5 to 7 return 8'hFF.
- R12: A read of a local register, a missed read or a wide read raises `host_rvalid` for exactly the one cycle after acceptance.
- R13: After reset, `pd_out` = 0, the control register reads 8'hC0, `pd_oe` = 1, the interrupt is low and no transfer cycle is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Block can take a request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | HOST_AW | Host byte address |
| host_size | input | 2 | Access size, 0 = byte |
| host_wdata | input | 8 | Write byte |
| host_rvalid | output | 1 | Read answer valid (one cycle) |
| host_rdata | output | 8 | Read answer byte |
| pd_out | output | 8 | Data latch driven to pins |
| pd_in | input | 8 | Data pins sampled |
| pd_oe | output | 1 | Data pins driven (forward) |
| ctl_strobe | output | 1 | Strobe line |
| ctl_autofd | output | 1 | Auto linefeed line |
| ctl_init | output | 1 | Reset/init line |
| ctl_select | output | 1 | Select printer line |
| st_busy | input | 1 | Busy status pin |
| st_ack_n | input | 1 | Acknowledge pin, active low |
| st_paper | input | 1 | Paper out pin |
| st_select | input | 1 | Selected pin |
| st_error | input | 1 | Error pin |
| st_timeout | input | 1 | Transfer timeout flag |
| epp_valid | output | 1 | Transfer cycle request |
| epp_ready | input | 1 | Sequencer finished the cycle |
| epp_write | output | 1 | Cycle is a write |
| epp_addr_cyc | output | 1 | 1 = address cycle, 0 = data cycle |
| epp_wdata | output | 8 | Byte to write |
| epp_rdata | input | 8 | Byte read, valid with epp_ready |
| irq_lines | output | NUM_IRQ | Interrupt lines, only IRQ_LINE used |

## Verification
The bench builds the block with `BASE_ADDR` = 16'h0278 and `IRQ_LINE` = 5, so both parameters move away from their defaults. This exposes an address decode or interrupt routing that is stuck at the default. It sweeps all 256 bytes through the data latch and the control register. It walks all 64 combinations of the six status pins and sixteen reverse-mode pin values. It then visits every offset with a missed address, a wide access, a delayed sequencer handshake and the interrupt enabled and disabled.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int OFF_W = 3;
  localparam logic [OFF_W-1:0] OFF_DATA   = 3'd0;
  localparam logic [OFF_W-1:0] OFF_STATUS = 3'd1;
  localparam logic [OFF_W-1:0] OFF_CTRL   = 3'd2;
  localparam logic [OFF_W-1:0] OFF_XADR   = 3'd3;
  localparam logic [OFF_W-1:0] OFF_XDAT   = 3'd4;
  localparam logic [1:0] SIZE_BYTE = 2'd0;
  localparam logic [7:0] FLOAT_BYTE = 8'hFF;
  localparam logic [7:0] CTRL_FORCE1 = 8'hC0;
  localparam logic [7:0] CTRL_KEEP   = 8'hDF;

  typedef struct packed {
    logic       wr;
    logic       addr_cyc;
    logic [7:0] data;
  } xfer_req_t;
endpackage

// File: rtl/lpt_ack_irq.sv
module lpt_ack_irq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n_pin,
  input  logic irq_en,
  input  logic clr,
  output logic ack_lvl,
  output logic irq
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q;
  logic irq_q;
  logic fall;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= ack_n_pin;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ack_n_pin};
    end
  endgenerate

  assign ack_lvl = sync_q[SYNC_STAGES-1];
  assign fall    = prev_q & ~ack_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= ack_lvl;
      if (fall && irq_en) irq_q <= 1'b1;
      else if (clr)       irq_q <= 1'b0;
    end
  end

  assign irq = irq_q;

  // R7
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(irq_en));

  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr) && !$past(fall && irq_en)) |-> !irq_q);
endmodule

// File: rtl/lpt_xfer_engine.sv
module lpt_xfer_engine
  import lpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  xfer_req_t  req,
  output logic       busy,
  output logic       epp_valid,
  output logic       epp_write,
  output logic       epp_addr_cyc,
  output logic [7:0] epp_wdata,
  input  logic       epp_ready,
  output logic       rd_done
);
  logic      valid_q;
  xfer_req_t req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      req_q   <= '0;
    end else if (!valid_q) begin
      if (start) begin
        valid_q <= 1'b1;
        req_q   <= req;
      end
    end else if (epp_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign busy         = valid_q;
  assign epp_valid    = valid_q;
  assign epp_write    = req_q.wr;
  assign epp_addr_cyc = req_q.addr_cyc;
  assign epp_wdata    = req_q.data;
  assign rd_done      = valid_q & epp_ready & ~req_q.wr;

  // R9
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (epp_valid && !epp_ready) |=> (epp_valid && $stable(epp_wdata)
                                   && $stable(epp_write) && $stable(epp_addr_cyc)));
endmodule

// File: rtl/lpt_regif.sv
module lpt_regif
  import lpt_pkg::*;
#(
  parameter int          HOST_AW     = 16,
  parameter logic [15:0] BASE_ADDR   = 16'h0378,
  parameter int          NUM_IRQ     = 16,
  parameter int          IRQ_LINE    = 7,
  parameter int          SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_valid,
  output logic               host_ready,
  input  logic               host_write,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [1:0]         host_size,
  input  logic [7:0]         host_wdata,
  output logic               host_rvalid,
  output logic [7:0]         host_rdata,
  output logic [7:0]         pd_out,
  input  logic [7:0]         pd_in,
  output logic               pd_oe,
  output logic               ctl_strobe,
  output logic               ctl_autofd,
  output logic               ctl_init,
  output logic               ctl_select,
  input  logic               st_busy,
  input  logic               st_ack_n,
  input  logic               st_paper,
  input  logic               st_select,
  input  logic               st_error,
  input  logic               st_timeout,
  output logic               epp_valid,
  input  logic               epp_ready,
  output logic               epp_write,
  output logic               epp_addr_cyc,
  output logic [7:0]         epp_wdata,
  input  logic [7:0]         epp_rdata,
  output logic [NUM_IRQ-1:0] irq_lines
);
  localparam int DEC_W = HOST_AW - OFF_W;
  localparam logic [DEC_W-1:0] WIN = BASE_ADDR[HOST_AW-1:OFF_W];

  logic [7:0]       data_q, ctrl_q;
  logic             rev_q;
  logic             rvalid_q;
  logic [7:0]       rdata_q;
  logic             accept, hit, ok, wr_ok, rd_ok, xfer_start;
  logic [OFF_W-1:0] off;
  logic             xfer_busy, xfer_rd_done;
  logic             ack_lvl, irq;
  logic             status_clr;
  logic [7:0]       status_byte, rd_mux;
  xfer_req_t        xreq;

  assign accept     = host_valid & host_ready;
  assign off        = host_addr[OFF_W-1:0];
  assign hit        = (host_addr[HOST_AW-1:OFF_W] == WIN);
  assign ok         = accept & hit & (host_size == SIZE_BYTE);
  assign wr_ok      = ok & host_write;
  assign rd_ok      = ok & ~host_write;
  assign xfer_start = ok & ((off == OFF_XADR) | (off == OFF_XDAT));
  assign status_clr = rd_ok & (off == OFF_STATUS);

  assign xreq.wr       = host_write;
  assign xreq.addr_cyc = (off == OFF_XADR);
  assign xreq.data     = host_wdata;

  lpt_xfer_engine u_xfer (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (xfer_start),
    .req          (xreq),
    .busy         (xfer_busy),
    .epp_valid    (epp_valid),
    .epp_write    (epp_write),
    .epp_addr_cyc (epp_addr_cyc),
    .epp_wdata    (epp_wdata),
    .epp_ready    (epp_ready),
    .rd_done      (xfer_rd_done)
  );

  lpt_ack_irq #(.SYNC_STAGES(SYNC_STAGES)) u_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_n_pin (st_ack_n),
    .irq_en    (ctrl_q[4]),
    .clr       (status_clr),
    .ack_lvl   (ack_lvl),
    .irq       (irq)
  );

  assign host_ready = ~xfer_busy;

  // local register state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 8'h00;
      ctrl_q <= CTRL_FORCE1;
      rev_q  <= 1'b0;
    end else begin
      if (wr_ok && off == OFF_DATA)
        data_q <= host_wdata;
      else if (rd_ok && off == OFF_DATA && rev_q)
        data_q <= pd_in;
      if (wr_ok && off == OFF_CTRL) begin
        ctrl_q <= (host_wdata | CTRL_FORCE1) & CTRL_KEEP;
        rev_q  <= host_wdata[5];
      end
    end
  end

  assign status_byte = {st_busy, ack_lvl, st_paper, st_select, st_error,
                        irq, 1'b1, st_timeout};

  always_comb begin
    rd_mux = FLOAT_BYTE;
    if (ok) begin
      case (off)
        OFF_DATA:   rd_mux = rev_q ? pd_in : data_q;
        OFF_STATUS: rd_mux = status_byte;
        OFF_CTRL:   rd_mux = ctrl_q;
        default:    rd_mux = FLOAT_BYTE;
      endcase
    end
  end

  // read response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= 8'h00;
    end else begin
      rvalid_q <= (accept & ~host_write & ~xfer_start) | xfer_rd_done;
      if (xfer_rd_done)
        rdata_q <= epp_rdata;
      else if (accept && !host_write)
        rdata_q <= rd_mux;
    end
  end

  assign host_rvalid = rvalid_q;
  assign host_rdata  = rdata_q;
  assign pd_out      = data_q;
  assign pd_oe       = ~rev_q;
  assign ctl_strobe  = ctrl_q[0];
  assign ctl_autofd  = ctrl_q[1];
  assign ctl_init    = ctrl_q[2];
  assign ctl_select  = ctrl_q[3];

  generate
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
      if (i == IRQ_LINE) begin : g_used
        assign irq_lines[i] = irq;
      end else begin : g_idle
        assign irq_lines[i] = 1'b0;
      end
    end
  endgenerate

  // R1
  miss_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && host_write && !hit) |=> ($stable(pd_out) && $stable(pd_oe)
      && $stable(ctl_strobe) && $stable(ctl_init) && !$rose(epp_valid)));

  // R2
  wide_no_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && host_size != SIZE_BYTE) |=> (!$rose(epp_valid) && $stable(pd_out)));

  // R9
  ready_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    epp_valid |-> !host_ready);

  // R12
  rvalid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> ($past(accept && !host_write && !xfer_start) || $past(xfer_rd_done)));

  // R4
  ctrl_read_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_ok && off == OFF_CTRL) |-> (host_rvalid && host_rdata[7:5] == 3'b110));

  // R7
  irq_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lines));
endmodule

// File: tb/lpt_regif_tb.sv
module lpt_regif_tb;
  localparam logic [15:0] BASE = 16'h0278;
  localparam int IRQL = 5;
  localparam int NIRQ = 16;

  logic clk = 0, rst_n = 0;
  logic host_valid = 0, host_write = 0;
  logic [15:0] host_addr = 0;
  logic [1:0] host_size = 0;
  logic [7:0] host_wdata = 0;
  logic host_ready, host_rvalid;
  logic [7:0] host_rdata, pd_out;
  logic [7:0] pd_in = 0;
  logic pd_oe, ctl_strobe, ctl_autofd, ctl_init, ctl_select;
  logic st_busy = 0, st_ack_n = 1, st_paper = 0, st_select = 0, st_error = 0, st_timeout = 0;
  logic epp_valid, epp_write, epp_addr_cyc;
  logic epp_ready = 0;
  logic [7:0] epp_wdata;
  logic [7:0] epp_rdata = 0;
  logic [NIRQ-1:0] irq_lines;

  int checks = 0, failures = 0;
  bit finished = 0;
  int xfer_count = 0;
  logic cap_wr, cap_adr;
  logic [7:0] cap_data;
  logic [7:0] rsp_val = 8'h00;

  always #5 clk = ~clk;

  lpt_regif #(.BASE_ADDR(BASE), .IRQ_LINE(IRQL), .NUM_IRQ(NIRQ)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_write(host_write), .host_addr(host_addr), .host_size(host_size),
    .host_wdata(host_wdata), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .pd_out(pd_out), .pd_in(pd_in), .pd_oe(pd_oe), .ctl_strobe(ctl_strobe),
    .ctl_autofd(ctl_autofd), .ctl_init(ctl_init), .ctl_select(ctl_select),
    .st_busy(st_busy), .st_ack_n(st_ack_n), .st_paper(st_paper), .st_select(st_select),
    .st_error(st_error), .st_timeout(st_timeout), .epp_valid(epp_valid),
    .epp_ready(epp_ready), .epp_write(epp_write), .epp_addr_cyc(epp_addr_cyc),
    .epp_wdata(epp_wdata), .epp_rdata(epp_rdata), .irq_lines(irq_lines));

  task automatic chk(input bit good, input string req, input int act, input int exp);
    checks++;
    if (!good) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [15:0] a, input logic [1:0] sz,
                     input logic [7:0] wd, output logic [7:0] rd, output int lat);
    while (!host_ready) @(negedge clk);
    host_valid = 1; host_write = wr; host_addr = a; host_size = sz; host_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    host_valid = 0;
    lat = 0; rd = 8'h00;
    if (!wr) begin
      lat = 1;
      while (!host_rvalid && lat < 50) begin
        @(negedge clk);
        lat++;
      end
      rd = host_rdata;
    end
  endtask

  task automatic wr8(input logic [2:0] o, input logic [7:0] d);
    logic [7:0] r; int l;
    acc(1'b1, BASE + 16'(o), 2'd0, d, r, l);
  endtask

  task automatic rd8(input logic [2:0] o, output logic [7:0] d, output int l);
    acc(1'b0, BASE + 16'(o), 2'd0, 8'h00, d, l);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  // transfer-cycle responder with a three-cycle delay
  initial begin
    forever begin
      @(negedge clk);
      if (epp_valid) begin
        for (int k = 0; k < 3; k++) begin
          chk(!host_ready, "R9 host_ready low while cycle pending", host_ready, 0);
          @(negedge clk);
        end
        cap_wr = epp_write; cap_adr = epp_addr_cyc; cap_data = epp_wdata;
        xfer_count++;
        epp_rdata = rsp_val;
        epp_ready = 1;
        @(negedge clk);
        epp_ready = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r; int l; int n0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk(pd_out == 8'h00, "R13 pd_out", pd_out, 0);
    chk(pd_oe == 1'b1, "R13 pd_oe", pd_oe, 1);
    chk(irq_lines == '0, "R13 irq", irq_lines, 0);
    chk(!epp_valid && host_ready, "R13 no cycle", epp_valid, 0);
    chk({ctl_select, ctl_init, ctl_autofd, ctl_strobe} == 4'h0, "R13 ctl pins", ctl_strobe, 0);
    rd8(3'd2, r, l);
    chk(r == 8'hC0, "R13 control reset", r, 8'hC0);

    // R3 data latch sweep
    for (int v = 0; v < 256; v++) begin
      wr8(3'd0, 8'(v));
      chk(pd_out == 8'(v), "R3 pd_out", pd_out, v);
      rd8(3'd0, r, l);
      chk(r == 8'(v), "R3 readback", r, v);
      chk(l == 1, "R12 read latency", l, 1);
    end

    // R4/R5 control sweep
    for (int v = 0; v < 256; v++) begin
      logic [7:0] e;
      e = (8'(v) | 8'hC0) & 8'hDF;
      wr8(3'd2, 8'(v));
      chk({ctl_select, ctl_init, ctl_autofd, ctl_strobe} == 4'(v), "R4 ctl pins",
          {ctl_select, ctl_init, ctl_autofd, ctl_strobe}, v & 15);
      chk(pd_oe == !v[5], "R5 direction", pd_oe, !v[5]);
      rd8(3'd2, r, l);
      chk(r == e, "R4 control read", r, e);
    end
    wr8(3'd2, 8'h00);

    // R6 status sweep
    for (int v = 0; v < 64; v++) begin
      logic [7:0] e;
      st_busy = v[5]; st_ack_n = v[4]; st_paper = v[3];
      st_select = v[2]; st_error = v[1]; st_timeout = v[0];
      settle();
      e = {v[5], v[4], v[3], v[2], v[1], 1'b0, 1'b1, v[0]};
      rd8(3'd1, r, l);
      chk(r == e, "R6 status byte", r, e);
    end
    st_ack_n = 1; settle();
    rd8(3'd1, r, l);

    // R5 reverse reads
    wr8(3'd0, 8'h3C);
    wr8(3'd2, 8'h20);
    chk(pd_oe == 0, "R5 reverse pd_oe", pd_oe, 0);
    for (int v = 0; v < 16; v++) begin
      pd_in = 8'(v * 17 + 3);
      rd8(3'd0, r, l);
      chk(r == pd_in, "R5 reverse read", r, pd_in);
      chk(pd_out == pd_in, "R5 latch update", pd_out, pd_in);
    end
    wr8(3'd2, 8'h00);
    rd8(3'd0, r, l);
    chk(r == 8'(15 * 17 + 3), "R5 forward after reverse", r, 15 * 17 + 3);

    // R1 address miss
    wr8(3'd0, 8'h5A);
    acc(1'b1, BASE + 16'd8, 2'd0, 8'hA5, r, l);
    acc(1'b1, BASE ^ 16'h0100, 2'd0, 8'h0F, r, l);
    acc(1'b1, BASE + 16'd10, 2'd0, 8'h3F, r, l);
    chk(pd_out == 8'h5A, "R1 miss write ignored", pd_out, 8'h5A);
    chk(ctl_strobe == 0 && pd_oe == 1, "R1 miss ctrl ignored", ctl_strobe, 0);
    acc(1'b0, BASE + 16'd8, 2'd0, 8'h00, r, l);
    chk(r == 8'hFF, "R1 miss read", r, 8'hFF);
    chk(l == 1, "R12 miss read latency", l, 1);

    // R2 wide access
    n0 = xfer_count;
    for (int s = 1; s < 4; s++) begin
      acc(1'b1, BASE, 2'(s), 8'h11, r, l);
      acc(1'b1, BASE + 16'd2, 2'(s), 8'h2F, r, l);
      acc(1'b1, BASE + 16'd4, 2'(s), 8'h77, r, l);
      acc(1'b0, BASE + 16'd2, 2'(s), 8'h00, r, l);
      chk(r == 8'hFF, "R2 wide read", r, 8'hFF);
    end
    repeat (6) @(negedge clk);
    chk(pd_out == 8'h5A, "R2 wide write ignored", pd_out, 8'h5A);
    chk(ctl_strobe == 0 && pd_oe == 1, "R2 wide ctrl ignored", ctl_strobe, 0);
    chk(xfer_count == n0, "R2 no cycle", xfer_count, n0);

    // R11 ignored offsets
    wr8(3'd1, 8'hFF);
    for (int o = 5; o < 8; o++) begin
      wr8(3'(o), 8'hFF);
      rd8(3'(o), r, l);
      chk(r == 8'hFF, "R11 unused read", r, 8'hFF);
    end
    rd8(3'd0, r, l);
    chk(r == 8'h5A, "R11 data untouched", r, 8'h5A);
    rd8(3'd2, r, l);
    chk(r == 8'hC0, "R11 control untouched", r, 8'hC0);
    chk(xfer_count == n0, "R11 no cycle", xfer_count, n0);

    // R7 disabled: no interrupt
    st_ack_n = 0; settle(); st_ack_n = 1; settle();
    chk(irq_lines == '0, "R7 disabled no irq", irq_lines, 0);
    // R7 enabled
    wr8(3'd2, 8'h10);
    st_ack_n = 0; settle();
    chk(irq_lines == NIRQ'(1) << IRQL, "R7 irq line", irq_lines, 1 << IRQL);
    st_ack_n = 1; settle();
    chk(irq_lines == NIRQ'(1) << IRQL, "R7 irq held", irq_lines, 1 << IRQL);
    rd8(3'd1, r, l);
    chk(r[2] == 1'b1, "R6 irq bit in status", r[2], 1);
    @(negedge clk);
    chk(irq_lines == '0, "R8 status read clears", irq_lines, 0);
    rd8(3'd1, r, l);
    chk(r[2] == 1'b0, "R8 irq bit cleared", r[2], 0);
    wr8(3'd2, 8'h00);

    // R9 write cycles
    for (int v = 0; v < 8; v++) begin
      n0 = xfer_count;
      wr8(3'd3 + 3'(v & 1), 8'(v * 37));
      while (!host_ready) @(negedge clk);
      chk(xfer_count == n0 + 1, "R9 one cycle", xfer_count, n0 + 1);
      chk(cap_wr == 1, "R9 write flag", cap_wr, 1);
      chk(cap_adr == ((v & 1) == 0), "R9 address flag", cap_adr, (v & 1) == 0);
      chk(cap_data == 8'(v * 37), "R9 write byte", cap_data, v * 37);
    end

    // R10 read cycles
    for (int v = 0; v < 8; v++) begin
      rsp_val = 8'(v * 29 + 1);
      rd8(3'd3 + 3'(v & 1), r, l);
      chk(cap_wr == 0, "R10 read flag", cap_wr, 0);
      chk(cap_adr == ((v & 1) == 0), "R10 address flag", cap_adr, (v & 1) == 0);
      chk(r == rsp_val, "R10 read byte", r, rsp_val);
      chk(l == 5, "R10 read latency", l, 5);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule